// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block decides the ordering of two unsigned words. Its building unit is a purely combinational slice that orders two 4-bit operands. Each slice has three cascade inputs (greater, less, equal) that come from the next less significant slice, and three result outputs of the same kind. When the slice's operands differ, the slice settles the outcome itself and disregards its cascade inputs. When the operands match, the slice forwards the cascade inputs according to a fixed resolution rule. That rule also gives defined results for cascade combinations that are not one-hot.

The top level chains a parameterized number of slices into a ripple so that it can order words of 4·N bits. The least significant slice receives the seed pattern greater=0, less=0, equal=1. Each slice's outputs drive the cascade inputs of the slice above it. The flags of the most significant slice are the block's outputs. There is no clock, reset or state. A result follows its operands through combinational logic only.

Top module: `mag_cmp_chain`

## Requirements
- R1: In a slice, bit 3 is the most significant operand bit. When the highest differing bit position has a 1 on the A side, the outputs are {greater,less,equal} = 100, whatever the cascade inputs hold.
- R2: In a slice, when the highest differing bit position has a 0 on the A side, the outputs are {greater,less,equal} = 010, whatever the cascade inputs hold.
- R3: In a slice with equal operands and cascade inputs {greater,less,equal} = 100, the outputs are 100.
- R4: In a slice with equal operands and cascade inputs {greater,less,equal} = 010, the outputs are 010.
- R5: In a slice with equal operands and the equal cascade input at 1, the outputs are 001, whatever the greater and less cascade inputs hold.
- R6: In a slice with equal operands and cascade inputs {greater,less,equal} = 110, all three outputs are 0.
- R7: In a slice with equal operands and cascade inputs {greater,less,equal} = 000, the outputs are 110.
- R8: The chain orders the two 4·N-bit words as unsigned numbers. Exactly one of a_gt, a_lt and a_eq is 1: a_gt when A>B, a_lt when A<B, and a_eq when A=B. A=B=0 gives a_eq.
- R9: In the chain, a difference in a more significant 4-bit group overrides any difference in less significant groups. Words that differ only in the least significant group are still ordered by that group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_word | input | 4·N_SLICES | First unsigned operand |
| b_word | input | 4·N_SLICES | Second unsigned operand |
| a_gt | output | 1 | High when a_word exceeds b_word |
| a_lt | output | 1 | High when a_word is below b_word |
| a_eq | output | 1 | High when the words match |

## Verification
Every result of this block is due in the same cycle as its stimulus, because nothing in the slice or the ripple is registered. The driver applies operands and cascade values 1 ns after a rising edge and queues the expected flags at the same moment. The monitor pops and compares them at the following falling edge, by which time the ripple has settled. The slice is swept through all 2048 operand and cascade combinations. The chain receives group-boundary cases and random wide words.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

    localparam int NIB_W = 4;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } cmp_flags_t;

    localparam cmp_flags_t CASC_SEED = 3'b001;
    localparam cmp_flags_t FLAGS_ABOVE = 3'b100;
    localparam cmp_flags_t FLAGS_BELOW = 3'b010;

endpackage

// File: rtl/mag_cmp_msd.sv
module mag_cmp_msd #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_val,
    input  logic [W-1:0] b_val,
    output logic         differ,
    output logic         a_high
);

    logic [W-1:0] diff_bits;

    assign diff_bits = a_val ^ b_val;

    // Scan upward so that the highest differing position wins.
    always_comb begin
        differ = 1'b0;
        a_high = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (diff_bits[i]) begin
                differ = 1'b1;
                a_high = a_val[i];
            end
        end
    end

endmodule

// File: rtl/mag_cmp_resolve.sv
module mag_cmp_resolve
    import mag_cmp_pkg::*;
(
    input  logic       differ,
    input  logic       a_high,
    input  cmp_flags_t casc_in,
    output cmp_flags_t result
);

    always_comb begin
        if (differ) begin
            result = a_high ? FLAGS_ABOVE : FLAGS_BELOW;
        end else begin
            // Equal operands: equal input dominates, otherwise each flag
            // rises unless the opposite cascade flag is present.
            result.eq = casc_in.eq;
            result.gt = !casc_in.eq && !casc_in.lt;
            result.lt = !casc_in.eq && !casc_in.gt;
        end
    end

endmodule

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
    import mag_cmp_pkg::*;
#(
    parameter int SLICE_W = NIB_W
) (
    input  logic [SLICE_W-1:0] a_nib,
    input  logic [SLICE_W-1:0] b_nib,
    input  logic               in_gt,
    input  logic               in_lt,
    input  logic               in_eq,
    output logic               out_gt,
    output logic               out_lt,
    output logic               out_eq
);

    logic       differ;
    logic       a_high;
    cmp_flags_t casc_flags;
    cmp_flags_t res_flags;

    assign casc_flags.gt = in_gt;
    assign casc_flags.lt = in_lt;
    assign casc_flags.eq = in_eq;

    mag_cmp_msd #(.W(SLICE_W)) u_msd (
        .a_val  (a_nib),
        .b_val  (b_nib),
        .differ (differ),
        .a_high (a_high)
    );

    mag_cmp_resolve u_resolve (
        .differ  (differ),
        .a_high  (a_high),
        .casc_in (casc_flags),
        .result  (res_flags)
    );

    assign out_gt = res_flags.gt;
    assign out_lt = res_flags.lt;
    assign out_eq = res_flags.eq;

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
    import mag_cmp_pkg::*;
#(
    parameter  int N_SLICES = 4,
    localparam int WORD_W   = N_SLICES * NIB_W
) (
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    output logic              a_gt,
    output logic              a_lt,
    output logic              a_eq
);

    logic [N_SLICES:0] rip_gt;
    logic [N_SLICES:0] rip_lt;
    logic [N_SLICES:0] rip_eq;

    assign rip_gt[0] = CASC_SEED.gt;
    assign rip_lt[0] = CASC_SEED.lt;
    assign rip_eq[0] = CASC_SEED.eq;

    for (genvar g = 0; g < N_SLICES; g++) begin : g_slice
        mag_cmp_slice #(.SLICE_W(NIB_W)) u_slc (
            .a_nib  (a_word[g*NIB_W +: NIB_W]),
            .b_nib  (b_word[g*NIB_W +: NIB_W]),
            .in_gt  (rip_gt[g]),
            .in_lt  (rip_lt[g]),
            .in_eq  (rip_eq[g]),
            .out_gt (rip_gt[g+1]),
            .out_lt (rip_lt[g+1]),
            .out_eq (rip_eq[g+1])
        );
    end

    assign a_gt = rip_gt[N_SLICES];
    assign a_lt = rip_lt[N_SLICES];
    assign a_eq = rip_eq[N_SLICES];

endmodule

// File: rtl/mag_cmp_chk.sv
module mag_cmp_slice_chk #(
    parameter int SLICE_W = 4
) (
    input logic [SLICE_W-1:0] a_nib,
    input logic [SLICE_W-1:0] b_nib,
    input logic               in_gt,
    input logic               in_lt,
    input logic               in_eq,
    input logic               out_gt,
    input logic               out_lt,
    input logic               out_eq
);

    logic [2:0] outs;
    logic [2:0] cins;
    logic       same;

    assign outs = {out_gt, out_lt, out_eq};
    assign cins = {in_gt, in_lt, in_eq};
    assign same = (a_nib == b_nib);

    always_comb begin
        AST_A_ABOVE: assert (!(a_nib > b_nib) || outs == 3'b100) else $error("slice above"); // R1
        AST_A_BELOW: assert (!(a_nib < b_nib) || outs == 3'b010) else $error("slice below"); // R2
        AST_CASC_GT_PASS: assert (!(same && cins == 3'b100) || outs == 3'b100) else $error("casc gt"); // R3
        AST_CASC_LT_PASS: assert (!(same && cins == 3'b010) || outs == 3'b010) else $error("casc lt"); // R4
        AST_CASC_EQ_WINS: assert (!(same && in_eq) || outs == 3'b001) else $error("casc eq"); // R5
        AST_CASC_BOTH_HIGH: assert (!(same && cins == 3'b110) || outs == 3'b000) else $error("casc both"); // R6
        AST_CASC_NONE: assert (!(same && cins == 3'b000) || outs == 3'b110) else $error("casc none"); // R7
    end

endmodule

module mag_cmp_chain_chk #(
    parameter int WORD_W = 16
) (
    input logic [WORD_W-1:0] a_word,
    input logic [WORD_W-1:0] b_word,
    input logic              a_gt,
    input logic              a_lt,
    input logic              a_eq
);

    always_comb begin
        AST_SINGLE_FLAG: assert ($countones({a_gt, a_lt, a_eq}) == 1) else $error("chain flags"); // R8
        AST_WORD_EQUAL: assert (a_eq == (a_word == b_word)) else $error("chain eq"); // R8
        AST_WORD_ORDER: assert (a_gt == (a_word > b_word) && a_lt == (a_word < b_word)) else $error("chain order"); // R9
    end

endmodule

bind mag_cmp_slice mag_cmp_slice_chk #(.SLICE_W(SLICE_W)) u_slice_chk (
    .a_nib  (a_nib),
    .b_nib  (b_nib),
    .in_gt  (in_gt),
    .in_lt  (in_lt),
    .in_eq  (in_eq),
    .out_gt (out_gt),
    .out_lt (out_lt),
    .out_eq (out_eq)
);

bind mag_cmp_chain mag_cmp_chain_chk #(.WORD_W(WORD_W)) u_chain_chk (
    .a_word (a_word),
    .b_word (b_word),
    .a_gt   (a_gt),
    .a_lt   (a_lt),
    .a_eq   (a_eq)
);

// File: tb/mag_cmp_chain_test.sv
`timescale 1ns/1ps
module mag_cmp_chain_test;

    localparam int N_SL   = 4;
    localparam int WIDE_W = N_SL * 4;

    typedef struct {
        bit          is_chain;
        logic [2:0]  exp;
        string       tag;
        logic [31:0] a;
        logic [31:0] b;
        logic [2:0]  c;
    } item_t;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [WIDE_W-1:0] w_a = '0;
    logic [WIDE_W-1:0] w_b = '0;
    logic              w_gt, w_lt, w_eq;

    logic [3:0] s_a = '0;
    logic [3:0] s_b = '0;
    logic       s_igt = 1'b0, s_ilt = 1'b0, s_ieq = 1'b0;
    logic       s_gt, s_lt, s_eq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    item_t sb_q[$];
    item_t cur;

    mag_cmp_chain #(.N_SLICES(N_SL)) uut (
        .a_word (w_a),
        .b_word (w_b),
        .a_gt   (w_gt),
        .a_lt   (w_lt),
        .a_eq   (w_eq)
    );

    mag_cmp_slice #(.SLICE_W(4)) slice_uut (
        .a_nib  (s_a),
        .b_nib  (s_b),
        .in_gt  (s_igt),
        .in_lt  (s_ilt),
        .in_eq  (s_ieq),
        .out_gt (s_gt),
        .out_lt (s_lt),
        .out_eq (s_eq)
    );

    task automatic drive_slice(input logic [3:0] a, input logic [3:0] b, input logic [2:0] c);
        item_t it;
        @(posedge clk);
        #1;
        s_a = a; s_b = b; {s_igt, s_ilt, s_ieq} = c;
        it.is_chain = 1'b0; it.a = 32'(a); it.b = 32'(b); it.c = c;
        if (a > b) begin
            it.exp = 3'b100; it.tag = "R1";
        end else if (a < b) begin
            it.exp = 3'b010; it.tag = "R2";
        end else begin
            case (c)
                3'b100: begin it.exp = 3'b100; it.tag = "R3"; end
                3'b010: begin it.exp = 3'b010; it.tag = "R4"; end
                3'b110: begin it.exp = 3'b000; it.tag = "R6"; end
                3'b000: begin it.exp = 3'b110; it.tag = "R7"; end
                default: begin it.exp = 3'b001; it.tag = "R5"; end
            endcase
        end
        sb_q.push_back(it);
    endtask

    task automatic drive_chain(input logic [WIDE_W-1:0] a, input logic [WIDE_W-1:0] b, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        w_a = a; w_b = b;
        it.is_chain = 1'b1; it.a = 32'(a); it.b = 32'(b); it.c = 3'b001;
        it.tag = tag;
        it.exp = (a > b) ? 3'b100 : ((a < b) ? 3'b010 : 3'b001);
        sb_q.push_back(it);
    endtask

    // Monitor: results are combinational, compared half a period later.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            logic [2:0] got;
            cur = sb_q.pop_front();
            got = cur.is_chain ? {w_gt, w_lt, w_eq} : {s_gt, s_lt, s_eq};
            checks++;
            if (got !== cur.exp) begin
                errors++;
                $display("FAIL %s: a=%0h b=%0h casc=%b got=%b expected=%b",
                         cur.tag, cur.a, cur.b, cur.c, got, cur.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R8: zero words at start report equal
        drive_chain('0, '0, "R8");
        // Slice exhaustive sweep covers R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 2048; v++) begin
            logic [10:0] vv;
            vv = 11'(v);
            drive_slice(vv[10:7], vv[6:3], vv[2:0]);
        end
        // R9: group boundary cases
        drive_chain(16'h0001, 16'h0000, "R9");
        drive_chain(16'h0000, 16'h0001, "R9");
        drive_chain(16'h1000, 16'h0FFF, "R9");
        drive_chain(16'h0FFF, 16'h1000, "R9");
        drive_chain(16'hFFFF, 16'hFFFE, "R9");
        drive_chain(16'h8000, 16'h7FFF, "R9");
        drive_chain(16'h0100, 16'h00FF, "R9");
        drive_chain(16'hFFFF, 16'hFFFF, "R8");
        drive_chain(16'h5A5A, 16'h5A5A, "R8");
        // R8: random wide words, some forced equal
        for (int k = 0; k < 1500; k++) begin
            logic [WIDE_W-1:0] ra, rb;
            ra = WIDE_W'($urandom);
            rb = (k % 5 == 0) ? ra : WIDE_W'($urandom);
            if (k % 7 == 0) rb = ra ^ WIDE_W'(1 << (k % WIDE_W));
            drive_chain(ra, rb, "R8");
        end
        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule